// File: doc/BRIEF.md
# Compare-and-Branch Program Counter

This block is the conditional-branch datapath of a small 8-bit accumulator machine. It has three parts. An unsigned magnitude comparator reduces the two register values A and B to a 2-bit relation code. A decoder reads the current instruction byte and decides whether it is a jump whose condition is satisfied. A 4-bit program counter addresses a 16-byte program store and either holds, steps or loads a branch target.

An 8-bit subtractor also presents A − B, so that a register can be incremented by subtracting 0xFF. The control sequencer raises `jmp_stb` while a jump instruction is current. If the decoder reports a satisfied condition in that cycle, the counter takes the target on the next edge. Otherwise it carries on counting.

The counter chooses one of three named actions every cycle:
- **ACT_HOLD**: the count is kept.
- **ACT_STEP**: the count advances by one.
- **ACT_LOAD**: the count takes the target.

The transitions are:
- **LOAD-over-STEP**: a taken strobe wins over the count enable.
- **STEP-on-enable**: used when there is no taken strobe.
- **HOLD-otherwise**: used in every other case.

Instruction layout: bits[7:6] = 2'b11 marks a conditional jump, bits[5:4] hold the required relation code, and bits[3:0] hold the target.

Top module: `cmp_branch_pc`

## Requirements
- R1: `cmp_code` is 2'b01 when A < B, 2'b11 when A = B and 2'b10 when A > B, comparing unsigned. It is combinational and never 2'b00.
- R2: `jmp_taken` is high exactly when instr[7:6] = 2'b11 and either instr[5:4] = 2'b00 (unconditional) or instr[5:4] equals `cmp_code`. It is combinational and independent of the strobe.
- R3: When `rst` is high at a rising clock edge, `pc` becomes 0.
- R4: With no load and `cnt_en` high, `pc` increases by one at the edge, wrapping from 15 to 0.
- R5: With no load and `cnt_en` low, `pc` keeps its value.
- R6: When `jmp_stb` and `jmp_taken` are both high, `pc` takes instr[3:0] at the edge, whatever the value of `cnt_en`.
- R7: A strobe while `jmp_taken` is low (a non-jump opcode or an unmet condition) leaves the counter to R4/R5.
- R8: `diff` equals A − B modulo 256. With B = 8'hFF this is A + 1.
- R9: After a load, counting resumes upward from the loaded target. A loop x=0; while x<10: x+=1 built on this block exits with x = 10 and with the expected address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Advance the counter this cycle |
| jmp_stb | input | 1 | Sequencer strobe marking a jump cycle |
| reg_a | input | 8 | Register A value |
| reg_b | input | 8 | Register B value |
| instr | input | 8 | Current instruction byte |
| pc | output | 4 | Program counter |
| cmp_code | output | 2 | Relation code of A against B |
| jmp_taken | output | 1 | Current instruction is a jump whose condition holds |
| diff | output | 8 | A − B modulo 256 |

## Verification
A load and an increment can both be requested in the same cycle: a taken strobe arriving while `cnt_en` is high. The LOAD-over-STEP transition must win. The bench provokes this with random strobes over random instructions and operands, often with enable high. Directed cycles put a taken jump on address 15, where a step would wrap, and a refused strobe next to an enable. A reference model predicts the next count from the relation code and the decoded condition, and each edge is judged against it, as is the jump loop's exit value.

// File: rtl/cbpc_pkg.sv
package cbpc_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        CMP_NONE = 2'b00,
        CMP_LT   = 2'b01,
        CMP_GT   = 2'b10,
        CMP_EQ   = 2'b11
    } cmp_code_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_STEP = 2'b01,
        ACT_LOAD = 2'b10
    } pc_act_t;

    localparam logic [1:0] OP_JUMP = 2'b11;

endpackage

// File: rtl/cbpc_compare.sv
module cbpc_compare
    import cbpc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] val_a,
    input  logic [W-1:0] val_b,
    output cmp_code_t    code
);

    always_comb begin
        if (val_a < val_b)
            code = CMP_LT;
        else if (val_a > val_b)
            code = CMP_GT;
        else
            code = CMP_EQ;
    end

endmodule

// File: rtl/cbpc_subtract.sv
module cbpc_subtract #(
    parameter int W = 8
) (
    input  logic [W-1:0] minuend,
    input  logic [W-1:0] subtrahend,
    output logic [W-1:0] result
);

    logic [W:0] sum_ext;

    // Two's-complement subtract: A + ~B + 1
    always_comb begin
        sum_ext = {1'b0, minuend} + {1'b0, ~subtrahend} + {{W{1'b0}}, 1'b1};
        result  = sum_ext[W-1:0];
    end

endmodule

// File: rtl/cbpc_decode.sv
module cbpc_decode
    import cbpc_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 4
) (
    input  logic [W-1:0]  instr,
    input  cmp_code_t     rel,
    output logic          taken,
    output logic [AW-1:0] target
);

    localparam int OP_HI   = W - 1;
    localparam int COND_HI = W - 3;

    logic [1:0] op_fld;
    logic [1:0] cond_fld;

    always_comb begin
        op_fld   = instr[OP_HI -: 2];
        cond_fld = instr[COND_HI -: 2];
        target   = instr[AW-1:0];
        taken    = 1'b0;
        if (op_fld == OP_JUMP) begin
            unique case (cond_fld)
                2'b00:   taken = 1'b1;
                default: taken = (cond_fld == rel);
            endcase
        end
    end

endmodule

// File: rtl/cbpc_counter.sv
module cbpc_counter
    import cbpc_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_en,
    input  logic          load_en,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] count
);

    pc_act_t       act;
    logic [AW-1:0] count_nx;

    // Action select: LOAD-over-STEP, STEP-on-enable, HOLD-otherwise
    always_comb begin
        if (load_en)
            act = ACT_LOAD;
        else if (step_en)
            act = ACT_STEP;
        else
            act = ACT_HOLD;
    end

    always_comb begin
        unique case (act)
            ACT_LOAD: count_nx = load_val;
            ACT_STEP: count_nx = count + {{(AW-1){1'b0}}, 1'b1};
            default:  count_nx = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else
            count <= count_nx;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> count == '0); // R3

    AST_LOAD_TARGET: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load_en)) |-> count == $past(load_val)); // R6

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_en) && $past(step_en))
            |-> count == $past(count) + {{(AW-1){1'b0}}, 1'b1}); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_en) && !$past(step_en))
            |-> $stable(count)); // R5

endmodule

// File: rtl/cmp_branch_pc.sv
module cmp_branch_pc
    import cbpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_en,
    input  logic       jmp_stb,
    input  logic [7:0] reg_a,
    input  logic [7:0] reg_b,
    input  logic [7:0] instr,
    output logic [3:0] pc,
    output logic [1:0] cmp_code,
    output logic       jmp_taken,
    output logic [7:0] diff
);

    cmp_code_t           rel;
    logic [ADDR_W-1:0]   tgt;
    logic                load_req;

    cbpc_compare #(.W(DATA_W)) u_cmp (
        .val_a (reg_a),
        .val_b (reg_b),
        .code  (rel)
    );

    cbpc_decode #(.W(DATA_W), .AW(ADDR_W)) u_dec (
        .instr  (instr),
        .rel    (rel),
        .taken  (jmp_taken),
        .target (tgt)
    );

    cbpc_subtract #(.W(DATA_W)) u_sub (
        .minuend    (reg_a),
        .subtrahend (reg_b),
        .result     (diff)
    );

    assign load_req = jmp_stb & jmp_taken;
    assign cmp_code = rel;

    cbpc_counter #(.AW(ADDR_W)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .step_en  (cnt_en),
        .load_en  (load_req),
        .load_val (tgt),
        .count    (pc)
    );

    AST_CODE_VALID: assert property (@(posedge clk) disable iff (rst)
        cmp_code != 2'b00); // R1

    AST_TAKE_NEEDS_JUMP: assert property (@(posedge clk) disable iff (rst)
        jmp_taken |-> instr[7:6] == 2'b11); // R2

    AST_REFUSED_STROBE: assert property (@(posedge clk) disable iff (rst)
        (jmp_stb && !jmp_taken && !cnt_en) |=> $stable(pc)); // R7

    AST_INC_IDIOM: assert property (@(posedge clk) disable iff (rst)
        (reg_b == 8'hFF) |-> diff == reg_a + 8'd1); // R8

endmodule

// File: tb/cmp_branch_pc_test.sv
module cmp_branch_pc_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       jmp_stb = 1'b0;
    logic [7:0] reg_a = 8'd0;
    logic [7:0] reg_b = 8'd0;
    logic [7:0] instr = 8'd0;
    logic [3:0] pc;
    logic [1:0] cmp_code;
    logic       jmp_taken;
    logic [7:0] diff;

    int n_run  = 0;
    int n_fail = 0;
    logic [3:0] exp_pc = 4'd0;
    logic [7:0] mem [16];

    always #5 clk = ~clk;

    cmp_branch_pc uut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .jmp_stb(jmp_stb),
        .reg_a(reg_a), .reg_b(reg_b), .instr(instr),
        .pc(pc), .cmp_code(cmp_code), .jmp_taken(jmp_taken), .diff(diff)
    );

    function automatic logic [1:0] ref_cmp(input logic [7:0] a, input logic [7:0] b);
        if (a < b)      return 2'b01;
        else if (a > b) return 2'b10;
        else            return 2'b11;
    endfunction

    function automatic logic ref_take(input logic [7:0] ins, input logic [1:0] c);
        return (ins[7:6] == 2'b11) && (ins[5:4] == 2'b00 || ins[5:4] == c);
    endfunction

    task automatic check(input string req, input int act, input int expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // One cycle: drive at negedge, check combinational outputs, then the count after the edge
    task automatic step(input logic r, input logic ce, input logic st,
                        input logic [7:0] a, input logic [7:0] b, input logic [7:0] ins,
                        input string req);
        logic [1:0] c;
        logic       tk;
        @(negedge clk);
        rst = r; cnt_en = ce; jmp_stb = st; reg_a = a; reg_b = b; instr = ins;
        #1;
        c  = ref_cmp(a, b);
        tk = ref_take(ins, c);
        check("R1 cmp_code", int'(cmp_code), int'(c));
        check("R2 jmp_taken", int'(jmp_taken), int'(tk));
        check("R8 diff", int'(diff), int'(8'(a - b)));
        if (r)            exp_pc = 4'd0;
        else if (st && tk) exp_pc = ins[3:0];
        else if (ce)      exp_pc = exp_pc + 4'd1;
        @(posedge clk);
        #1;
        check(req, int'(pc), int'(exp_pc));
    endtask

    initial begin
        #(200000 * 10);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int seed;
        int guard;
        seed = 32'h5eed_1234;
        void'($urandom(seed));

        // R3 reset state
        step(1'b1, 1'b1, 1'b0, 8'd0, 8'd0, 8'd0, "R3 reset");
        step(1'b1, 1'b0, 1'b0, 8'd5, 8'd9, 8'hC7, "R3 reset");

        // R4 counting and wrap 15 -> 0
        for (int i = 0; i < 17; i++)
            step(1'b0, 1'b1, 1'b0, 8'd1, 8'd2, 8'h00, "R4 step/wrap");
        // R5 hold
        step(1'b0, 1'b0, 1'b0, 8'd1, 8'd2, 8'h00, "R5 hold");
        // R7 refused strobe: non-jump opcode, and unmet condition
        step(1'b0, 1'b1, 1'b1, 8'd3, 8'd3, 8'h8A, "R7 non-jump strobe");
        step(1'b0, 1'b0, 1'b1, 8'd3, 8'd9, 8'hEA, "R7 unmet condition");
        // R6 load beats step, and loads with enable low
        step(1'b0, 1'b1, 1'b1, 8'd9, 8'd3, 8'hE9, "R6 load over step");
        step(1'b0, 1'b0, 1'b1, 8'd0, 8'hFF, 8'hD2, "R6 load enable low");
        // R9 counting resumes from target
        step(1'b0, 1'b1, 1'b0, 8'd0, 8'd0, 8'h00, "R9 resume");
        step(1'b0, 1'b1, 1'b0, 8'd0, 8'd0, 8'h00, "R9 resume");
        // R6 taken jump at address 15 (step would wrap)
        step(1'b0, 1'b1, 1'b1, 8'd7, 8'd7, 8'hFF, "R6 load to 15");
        step(1'b0, 1'b1, 1'b1, 8'd7, 8'd7, 8'hF5, "R6 load at 15");
        // R8 increment idiom corners
        step(1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'h00, "R8 corner");
        step(1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h00, "R8 corner");
        step(1'b0, 1'b0, 1'b0, 8'hFE, 8'hFF, 8'h00, "R8 corner");

        // Random stimulus with occasional reset
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a, b, ins;
            a   = 8'($urandom);
            b   = ($urandom % 4 == 0) ? a : 8'($urandom);
            ins = ($urandom % 2 == 0) ? {2'b11, 6'($urandom)} : 8'($urandom);
            step(($urandom % 50) == 0, 1'($urandom), ($urandom % 3) != 0,
                 a, b, ins, "R6 random count");
        end

        // R9 loop: x=0; while x<10: x+=1
        mem[0] = 8'h00;   // start
        mem[1] = 8'hF4;   // jump to 4 if A == B (B = 10)
        mem[2] = 8'h10;   // A <= A - 0xFF
        mem[3] = 8'hC1;   // unconditional jump to 1
        for (int i = 4; i < 16; i++) mem[i] = 8'h00;
        step(1'b1, 1'b0, 1'b0, 8'd0, 8'd0, 8'h00, "R3 loop reset");
        reg_a = 8'd0;
        guard = 0;
        begin
            logic [7:0] x;
            x = 8'd0;
            while (pc != 4'd4 && guard < 200) begin
                logic [7:0] ins, b;
                ins = mem[pc];
                b   = (ins == 8'h10) ? 8'hFF : 8'd10;
                step(1'b0, 1'b1, ins[7:6] == 2'b11, x, b, ins, "R9 loop pc");
                if (ins == 8'h10) x = x + 8'd1;
                guard++;
            end
            check("R9 loop exit x", int'(x), 10);
            check("R9 loop exit pc", int'(pc), 4);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule